// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It does this by walking a two-level translation table held in memory. A request carries the virtual address, a write flag and a user-mode flag. The block samples the directory base input when it accepts the request. It then makes two dependent word reads over a simple read port: first the directory entry, then the page-table entry that the directory entry points to.

A walk ends in one of two ways. On success, the block pulses `done` for one cycle and presents the physical address. On failure, it pulses `fault` for one cycle and presents a fault record: the virtual address, the access type, the privilege and a cause code.

The walker handles one walk at a time. It keeps no copy of any entry. Each walk therefore reads memory afresh, which makes changing the base input enough to switch address spaces.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `done`, `fault` and `mem_req_valid` are 0.
- R2: The first read of a walk is the directory entry, at address base + 4 × va[31:22]. The base is the value of `base_pa` in the cycle the request is accepted.
- R3: The second read is the table entry, at address {directory entry[31:12], va[21:12], 2'b00}.
- R4: When every check passes, `done` pulses for one cycle and `pa` equals {table entry[31:12], va[11:0]}.
- R5: If bit 0 (present) of the directory entry is clear, the walk faults with cause 1 and makes no second read.
- R6: If bit 0 (present) of the table entry is clear, the walk faults with cause 2.
- R7: A present table entry faults with cause 3 in either of two cases: a write when bit 1 (writable) is clear, or a user-mode access when bit 2 (user) is clear. Kernel-mode accesses ignore bit 2, and reads never need bit 1.
- R8: When `fault` is high, `fault_va`, `fault_write` and `fault_user` hold the request's address, write flag and user flag.
- R9: Only one walk runs at a time. `req_ready` is low from acceptance until the result, and a request presented while busy has no effect.
- R10: Once `mem_req_valid` is raised, it stays high with a stable `mem_req_addr` until `mem_req_ready` is seen.
- R11: `done` and `fault` are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_pa | input | 32 | Physical address of the directory page |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | High when idle; a request is accepted when both are high |
| req_va | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access |
| req_user | input | 1 | 1 for a user-mode access |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Word address of the read |
| mem_rsp_valid | input | 1 | Read data is valid (one cycle) |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | One-cycle pulse on a successful translation |
| pa | output | 32 | Translated physical address |
| fault | output | 1 | One-cycle pulse on a failed translation |
| fault_cause | output | 2 | 1 directory absent, 2 table entry absent, 3 access denied |
| fault_va | output | 32 | Virtual address of the walk |
| fault_write | output | 1 | Write flag of the walk |
| fault_user | output | 1 | User flag of the walk |

## Verification
The bound checker covers the properties that hold on every cycle. It checks the reset values, that a read request holds with a stable address while stalled, that `req_ready` is low during a memory request, that `done` and `fault` are exclusive single-cycle pulses, and that a fault never carries cause 0.

Only the bench scenarios can show the values that depend on table contents. These are the read addresses, the physical address, the cause chosen for each combination of flag bits and access type, the effect of switching the base between walks, and a request that is ignored during a walk. For these, a behavioural model reads the same memory the bench serves and is compared with the design on every clock.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] base_pa,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  input  logic        req_write,
  input  logic        req_user,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        done,
  output logic [31:0] pa,
  output logic        fault,
  output logic [1:0]  fault_cause,
  output logic [31:0] fault_va,
  output logic        fault_write,
  output logic        fault_user
);
  localparam int FRM_W = 32 - OFF_W;
  localparam int DIR_LO = OFF_W + IDX_W;

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DWAIT, S_TREQ, S_TWAIT} st_t;

  st_t         st;
  logic [31:0] va_q, addr_q;
  logic        wr_q, us_q;
  logic        perm_ok;
  logic        unused_bits;

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_DREQ) || (st == S_TREQ);
  assign mem_req_addr  = addr_q;
  assign fault_va      = va_q;
  assign fault_write   = wr_q;
  assign fault_user    = us_q;
  assign perm_ok       = (!wr_q || mem_rsp_data[1]) && (!us_q || mem_rsp_data[2]);
  assign unused_bits   = ^mem_rsp_data[OFF_W-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      va_q        <= '0;
      addr_q      <= '0;
      wr_q        <= 1'b0;
      us_q        <= 1'b0;
      done        <= 1'b0;
      fault       <= 1'b0;
      fault_cause <= 2'd0;
      pa          <= '0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          wr_q   <= req_write;
          us_q   <= req_user;
          addr_q <= base_pa + {{(30-IDX_W){1'b0}}, req_va[31:DIR_LO], 2'b00};
          st     <= S_DREQ;
        end
        S_DREQ: if (mem_req_ready) st <= S_DWAIT;
        S_DWAIT: if (mem_rsp_valid) begin
          if (!mem_rsp_data[0]) begin
            fault       <= 1'b1;
            fault_cause <= 2'd1;
            st          <= S_IDLE;
          end else begin
            addr_q <= {mem_rsp_data[31:OFF_W], va_q[DIR_LO-1:OFF_W], 2'b00};
            st     <= S_TREQ;
          end
        end
        S_TREQ: if (mem_req_ready) st <= S_TWAIT;
        S_TWAIT: if (mem_rsp_valid) begin
          st <= S_IDLE;
          if (!mem_rsp_data[0]) begin
            fault       <= 1'b1;
            fault_cause <= 2'd2;
          end else if (!perm_ok) begin
            fault       <= 1'b1;
            fault_cause <= 2'd3;
          end else begin
            done <= 1'b1;
            pa   <= {mem_rsp_data[31:32-FRM_W], va_q[OFF_W-1:0]};
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_cause
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !done && !fault && !mem_req_valid));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  assert_cause_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_cause != 2'd0));
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .done(done), .fault(fault),
  .fault_cause(fault_cause)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] base_pa = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        done;
  logic [31:0] pa;
  logic        fault;
  logic [1:0]  fault_cause;
  logic [31:0] fault_va;
  logic        fault_write;
  logic        fault_user;

  always #5 clk = ~clk;

  ptw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .base_pa(base_pa),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .pa(pa), .fault(fault),
    .fault_cause(fault_cause), .fault_va(fault_va),
    .fault_write(fault_write), .fault_user(fault_user)
  );

  logic [31:0] mem [int unsigned];
  int total = 0;
  int fails = 0;
  int cyc = 0;

  bit          pend = 0;
  int          exp_kind;
  logic [31:0] exp_pa, exp_va;
  bit          exp_w, exp_u;
  logic [31:0] exp_a [2];
  int          exp_n = 0, exp_i = 0;

  bit          hs = 0;
  logic [31:0] hs_addr = '0;
  bit          rsp_pend = 0;
  int          rsp_cnt = 0;
  logic [31:0] rsp_addr = '0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (done && fault) check(0, "R11 done and fault together", 32'd1, 32'd0);
      if (done || fault) begin
        if (!pend) check(0, "R11/R9 result with no walk pending", 32'd1, 32'd0);
        else begin
          check(done == (exp_kind == 0), "R4/R5/R6/R7 outcome kind", {31'd0, done}, exp_kind == 0 ? 32'd1 : 32'd0);
          if (done && exp_kind == 0) check(pa == exp_pa, "R4 physical address", pa, exp_pa);
          if (fault) begin
            check(fault_cause == exp_kind[1:0], "R5/R6/R7 fault cause", {30'd0, fault_cause}, exp_kind);
            check(fault_va == exp_va, "R8 fault va", fault_va, exp_va);
            check({fault_write, fault_user} == {exp_w, exp_u}, "R8 fault write/user",
                  {30'd0, fault_write, fault_user}, {30'd0, exp_w, exp_u});
          end
          check(exp_i == exp_n, "R5/R3 number of reads", exp_i, exp_n);
        end
        pend = 0;
      end
      if (hs) begin
        if (exp_i >= exp_n) check(0, "R5 unexpected extra read", hs_addr, 32'h0);
        else check(hs_addr == exp_a[exp_i], exp_i == 0 ? "R2 directory read address" : "R3 table read address",
                   hs_addr, exp_a[exp_i]);
        exp_i++;
        rsp_pend = 1;
        rsp_cnt  = cyc % 3;
        rsp_addr = hs_addr;
      end
    end
    mem_rsp_valid = 1'b0;
    if (rsp_pend) begin
      if (rsp_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = rd(rsp_addr);
        rsp_pend      = 0;
      end else rsp_cnt--;
    end
    mem_req_ready = (cyc % 4) != 1;
    hs      = rst_n && mem_req_valid && mem_req_ready;
    hs_addr = mem_req_addr;
  end

  task automatic walk(input logic [31:0] va, input bit w, input bit u, input bit poke);
    logic [31:0] da, pde, ta, pte;
    da = base_pa + {20'd0, va[31:22], 2'b00};
    pde = rd(da);
    exp_a[0] = da; exp_n = 1; exp_i = 0;
    exp_va = va; exp_w = w; exp_u = u;
    if (!pde[0]) exp_kind = 1;
    else begin
      ta = {pde[31:12], va[21:12], 2'b00};
      exp_a[1] = ta; exp_n = 2;
      pte = rd(ta);
      if (!pte[0]) exp_kind = 2;
      else if ((w && !pte[1]) || (u && !pte[2])) exp_kind = 3;
      else begin exp_kind = 0; exp_pa = {pte[31:12], va[11:0]}; end
    end
    while (!req_ready) @(negedge clk);
    req_va = va; req_write = w; req_user = u; req_valid = 1'b1; pend = 1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      check(!req_ready, "R9 ready low while busy", {31'd0, req_ready}, 32'd0);
      req_va = 32'h00800000; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (pend) @(negedge clk);
  endtask

  initial begin
    mem[32'h00100004] = 32'h00200001;
    mem[32'h00100008] = 32'h00000000;
    mem[32'h00200014] = 32'hABCDE007;
    mem[32'h00200018] = 32'h12345001;
    mem[32'h0020001C] = 32'h77777005;
    mem[32'h00200020] = 32'h99999006;
    mem[32'h00200024] = 32'h2468A003;
    mem[32'h00300004] = 32'h00400001;
    mem[32'h00400014] = 32'h55555007;
    base_pa = 32'h00100000;
    repeat (3) @(negedge clk);
    check(req_ready && !done && !fault && !mem_req_valid, "R1 reset state",
          {28'd0, req_ready, done, fault, mem_req_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_req_valid, "R1 idle after reset", {30'd0, req_ready, mem_req_valid}, 32'h2);
    walk(32'h00405123, 0, 1, 0);   // R4 user read, full permissions
    walk(32'h00405000, 1, 1, 1);   // R4 user write, R9 ignored request
    walk(32'h00406ABC, 0, 1, 0);   // R7 user access without user bit
    walk(32'h00406ABC, 0, 0, 0);   // R7 kernel ignores user bit
    walk(32'h00406FFF, 1, 0, 0);   // R7 kernel write to read-only
    walk(32'h00407FFF, 0, 1, 0);   // R7 user read of read-only user page
    walk(32'h00407010, 1, 1, 1);   // R7 user write to read-only
    walk(32'h00408000, 0, 0, 0);   // R6 entry with present clear but other bits set
    walk(32'h00800123, 1, 1, 0);   // R5 directory absent
    walk(32'h00C00000, 0, 0, 0);   // R5 directory entry never written
    walk(32'h00409FFF, 1, 0, 1);   // R4 kernel write to writable page
    walk(32'h00409FFF, 1, 1, 0);   // R7 user write without user bit
    base_pa = 32'h00300000;
    walk(32'h00405123, 0, 1, 0);   // R2 new base selects other space
    walk(32'h00406000, 0, 0, 0);   // R6 absent in new space
    repeat (3) @(negedge clk);
    check(!pend && req_ready, "R9 idle after last walk", {31'd0, req_ready}, 32'd1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule